// File: doc/BRIEF.md
# Peripheral Request Router with Grouped-Priority Channel Arbiter

This block sits between a set of peripherals that raise DMA service requests and a bank of DMA channels that share one memory port. Software programs a mapping table with one entry per peripheral request line. An entry holds a valid flag and a channel number. Every request line whose entry is valid is forwarded to the channel it names. When several lines point at the same channel, their requests are ORed together.

The second half of the block picks which channel may use the shared memory port. Channels are sorted into four priority levels by bits 3:2 of their index, so channels 16 apart share a level. The lowest-numbered level that has a ready channel always wins. Inside a level, the grant rotates round-robin.

The arbiter is a two-state machine:
- **ST_IDLE** has no grant. On the clock edge where some channel is ready, the transition *IDLE→BUSY (win)* registers a one-hot grant for the winner.
- **ST_BUSY** holds that grant unchanged. The transition *BUSY→IDLE (burst done)* clears the grant when `burst_done` is sampled high.
- The next arbitration happens at the following edge. Each grant is therefore followed by one idle cycle.

Top module: `dreq_route_arb`

## Requirements
- R1: After reset, every mapping entry reads back as 0, `ch_req` is all zero, `grant` is all zero and the arbiter is in ST_IDLE.
- R2: A write to an entry stores bit 7 as the valid flag and bits 4:0 as the channel number. Readback returns `{valid, 2'b00, channel}`, so bits 6:5 always read 0. A write takes effect from the cycle after the write edge.
- R3: The entry for request n < 64 sits at byte address 0x100 + 4·n. The entry for request n ≥ 64 sits at 0x1100 + 4·(n−64). A write is ignored, and a read returns 0, when the address is not a multiple of 4, lies outside both windows, or names a request index ≥ NUM_REQ.
- R4: `ch_req[c]` is the OR of `req_in[r]` over every request r whose entry is valid and names channel c. Request lines with no valid entry drive no channel.
- R5: Writing an entry with bit 7 clear removes the mapping: that request stops driving any channel, while the other entries are unaffected.
- R6: The priority level of a channel is bits 3:2 of its index, and level 0 is the highest. A ready channel in a higher level always wins over any ready channel in a lower level, regardless of index.
- R7: Inside a level, the search starts just after the channel last granted in that level and goes upward through the indices, wrapping around. After reset, every level starts its search at index 0.
- R8: A grant stays unchanged while the arbiter is in ST_BUSY, even if the channel drops `ch_ready`, until `burst_done` is sampled. The grant then reads zero from the next cycle.
- R9: `grant` is zero or one-hot, and it names only a channel that was ready at the edge where the arbitration took place. `burst_done` has no effect in ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Mapping table write strobe |
| cfg_addr | input | 13 | Byte address into the mapping windows |
| cfg_wdata | input | 8 | Entry write data |
| cfg_rdata | output | 8 | Entry readback at `cfg_addr`, combinational |
| req_in | input | NUM_REQ | Peripheral request lines |
| ch_req | output | NUM_CH | Request forwarded to each channel |
| ch_ready | input | NUM_CH | Channels ready for the memory port |
| burst_done | input | 1 | Granted channel ends its burst |
| grant | output | NUM_CH | One-hot memory port grant |

## Verification
The bench builds the block with NUM_REQ = 80 and NUM_CH = 32:
- With 80 request lines, both address windows are reachable. Index 80 is also reachable, so the ignored write to a request beyond NUM_REQ can be tested.
- With all 32 channels present, each level contains two groups of four channels 16 apart. This makes it possible to check that channel 16 beats channel 4, and that rotation crosses from the low group to the high group of the same level.

// File: rtl/dra_pkg.sv
package dra_pkg;
    localparam int unsigned ADDR_W    = 13;
    localparam int unsigned DATA_W    = 8;
    localparam int unsigned CHNUM_W   = 5;
    localparam int unsigned LVL_COUNT = 4;
    localparam int unsigned WIN_SLOTS = 64;

    localparam logic [4:0] WIN_LO_PAGE = 5'h01;
    localparam logic [4:0] WIN_HI_PAGE = 5'h11;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } arb_state_t;
endpackage

// File: rtl/dra_map_table.sv
module dra_map_table
    import dra_pkg::*;
#(
    parameter int unsigned NUM_REQ = 128
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [ADDR_W-1:0]                 cfg_addr,
    input  logic [DATA_W-1:0]                 cfg_wdata,
    output logic [DATA_W-1:0]                 cfg_rdata,
    output logic [NUM_REQ-1:0]                ent_vld,
    output logic [NUM_REQ-1:0][CHNUM_W-1:0]   ent_ch
);
    logic       in_lo;
    logic       in_hi;
    logic [6:0] slot_idx;
    logic       hit;

    always_comb begin
        in_lo    = (cfg_addr[12:8] == WIN_LO_PAGE);
        in_hi    = (cfg_addr[12:8] == WIN_HI_PAGE);
        slot_idx = {in_hi, cfg_addr[7:2]};
        hit      = (cfg_addr[1:0] == 2'b00) && (in_lo || in_hi)
                   && (int'(slot_idx) < int'(NUM_REQ));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_vld <= '0;
            ent_ch  <= '0;
        end else if (cfg_we && hit) begin
            ent_vld[slot_idx] <= cfg_wdata[7];
            ent_ch[slot_idx]  <= cfg_wdata[CHNUM_W-1:0];
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (hit) begin
            cfg_rdata = {ent_vld[slot_idx], 2'b00, ent_ch[slot_idx]};
        end
    end

    // R2: a stored entry reflects the written valid flag
    p_entry_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && hit) |=> (ent_vld[$past(slot_idx)] == $past(cfg_wdata[7])));

    // R5: writing with bit 7 clear removes the mapping
    p_entry_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && hit && !cfg_wdata[7]) |=> !ent_vld[$past(slot_idx)]);
endmodule

// File: rtl/dra_route.sv
module dra_route
    import dra_pkg::*;
#(
    parameter int unsigned NUM_REQ = 128,
    parameter int unsigned NUM_CH  = 32
) (
    input  logic [NUM_REQ-1:0]                req_in,
    input  logic [NUM_REQ-1:0]                ent_vld,
    input  logic [NUM_REQ-1:0][CHNUM_W-1:0]   ent_ch,
    output logic [NUM_CH-1:0]                 ch_req
);
    always_comb begin
        ch_req = '0;
        for (int r = 0; r < int'(NUM_REQ); r++) begin
            for (int c = 0; c < int'(NUM_CH); c++) begin
                if (req_in[r] && ent_vld[r] && (int'(ent_ch[r]) == c)) begin
                    ch_req[c] = 1'b1;
                end
            end
        end
    end

    // R4: no channel request without some raised request line
    always_comb begin
        a_route_src_r4: assert (!(|ch_req) || (|req_in));
    end
endmodule

// File: rtl/dra_arbiter.sv
module dra_arbiter
    import dra_pkg::*;
#(
    parameter int unsigned NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_ready,
    input  logic              burst_done,
    output logic [NUM_CH-1:0] grant
);
    localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    arb_state_t                        st_q;
    arb_state_t                        st_nxt;
    logic [NUM_CH-1:0]                 grant_q;
    logic [LVL_COUNT-1:0][CH_W-1:0]    last_q;
    logic                              win_found;
    logic [CH_W-1:0]                   win_idx;
    logic [1:0]                        win_lvl;

    always_comb begin
        int  cand;
        logic lvl_hit;
        win_found = 1'b0;
        win_idx   = '0;
        win_lvl   = '0;
        cand      = 0;
        for (int l = 0; l < int'(LVL_COUNT); l++) begin
            lvl_hit = 1'b0;
            if (!win_found) begin
                for (int k = 1; k <= int'(NUM_CH); k++) begin
                    cand = (int'(last_q[l]) + k) % int'(NUM_CH);
                    if (!lvl_hit && (((cand >> 2) & 3) == l) && ch_ready[cand]) begin
                        lvl_hit = 1'b1;
                        win_idx = CH_W'(cand);
                        win_lvl = 2'(l);
                    end
                end
            end
            if (lvl_hit) begin
                win_found = 1'b1;
            end
        end
    end

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE: if (win_found)  st_nxt = ST_BUSY;
            ST_BUSY: if (burst_done) st_nxt = ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= '0;
            for (int l = 0; l < int'(LVL_COUNT); l++) begin
                last_q[l] <= CH_W'(NUM_CH - 1);
            end
        end else begin
            unique case (st_q)
                ST_IDLE: if (win_found) begin
                    grant_q          <= NUM_CH'(1) << win_idx;
                    last_q[win_lvl]  <= win_idx;
                end
                ST_BUSY: if (burst_done) begin
                    grant_q <= '0;
                end
                default: grant_q <= '0;
            endcase
        end
    end

    assign grant = grant_q;

    // R9: grant is zero or one-hot
    p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_q));

    // R9: a fresh grant lands on a channel that was ready
    p_grant_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && (|ch_ready)) |=>
            (grant_q != '0) && ((grant_q & $past(ch_ready)) == grant_q));

    // R8: the grant is held through the burst
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BUSY && !burst_done) |=> ($stable(grant_q) && grant_q != '0));

    // R8: the grant is released after the burst ends
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BUSY && burst_done) |=> (grant_q == '0));
endmodule

// File: rtl/dreq_route_arb.sv
module dreq_route_arb
    import dra_pkg::*;
#(
    parameter int unsigned NUM_REQ = 128,
    parameter int unsigned NUM_CH  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [12:0]         cfg_addr,
    input  logic [7:0]          cfg_wdata,
    output logic [7:0]          cfg_rdata,
    input  logic [NUM_REQ-1:0]  req_in,
    output logic [NUM_CH-1:0]   ch_req,
    input  logic [NUM_CH-1:0]   ch_ready,
    input  logic                burst_done,
    output logic [NUM_CH-1:0]   grant
);
    logic [NUM_REQ-1:0]              ent_vld;
    logic [NUM_REQ-1:0][CHNUM_W-1:0] ent_ch;

    dra_map_table #(.NUM_REQ(NUM_REQ)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .ent_vld   (ent_vld),
        .ent_ch    (ent_ch)
    );

    dra_route #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_route (
        .req_in  (req_in),
        .ent_vld (ent_vld),
        .ent_ch  (ent_ch),
        .ch_req  (ch_req)
    );

    dra_arbiter #(.NUM_CH(NUM_CH)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .ch_ready   (ch_ready),
        .burst_done (burst_done),
        .grant      (grant)
    );
endmodule

// File: tb/dreq_route_arb_bench.sv
`timescale 1ns/1ps
module dreq_route_arb_bench;
    localparam int NREQ = 80;
    localparam int NCH  = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [12:0]     cfg_addr = '0;
    logic [7:0]      cfg_wdata = '0;
    logic [7:0]      cfg_rdata;
    logic [NREQ-1:0] req_in = '0;
    logic [NCH-1:0]  ch_req;
    logic [NCH-1:0]  ch_ready = '0;
    logic            burst_done = 1'b0;
    logic [NCH-1:0]  grant;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    dreq_route_arb #(.NUM_REQ(NREQ), .NUM_CH(NCH)) u_dreq_route_arb (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_in(req_in),
        .ch_req(ch_req), .ch_ready(ch_ready), .burst_done(burst_done),
        .grant(grant)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [12:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [12:0] a, input logic [7:0] exp);
        @(negedge clk);
        cfg_addr = a;
        #1;
        chk(tag, 64'(cfg_rdata), 64'(exp));
    endtask

    task automatic req_chk(input string tag, input logic [NREQ-1:0] r, input logic [NCH-1:0] exp);
        @(negedge clk);
        req_in = r;
        #1;
        chk(tag, 64'(ch_req), 64'(exp));
    endtask

    task automatic step_grant(input string tag, input int ch);
        @(posedge clk); #1;
        chk(tag, 64'(grant), 64'(NCH'(1) << ch));
    endtask

    task automatic finish_burst(input string tag);
        @(negedge clk);
        burst_done = 1'b1;
        @(posedge clk); #1;
        chk(tag, 64'(grant), 64'd0);
        @(negedge clk);
        burst_done = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        rd_chk("R1 entry after reset", 13'h114, 8'h00);
        #1;
        chk("R1 ch_req after reset", 64'(ch_req), 64'd0);
        chk("R1 grant after reset", 64'(grant), 64'd0);
    endtask

    task automatic t_map();
        wr(13'h0114, 8'h91);                            // req 5 -> ch 17
        rd_chk("R2 readback req5", 13'h0114, 8'h91);
        wr(13'h1118, 8'hE3);                            // req 70 -> ch 3
        rd_chk("R2 bits 6:5 read zero", 13'h1118, 8'h83);
        wr(13'h0118, 8'h91);                            // req 6 -> ch 17
        rd_chk("R3 low window no alias", 13'h0118, 8'h91);
        wr(13'h0115, 8'h00);
        rd_chk("R3 misaligned write ignored", 13'h0114, 8'h91);
        wr(13'h0014, 8'h00);
        rd_chk("R3 outside window ignored", 13'h0114, 8'h91);
        wr(13'h1140, 8'h85);                            // req 80 >= NUM_REQ
        rd_chk("R3 index beyond NUM_REQ", 13'h1140, 8'h00);
    endtask

    task automatic t_route();
        req_chk("R4 req5 to ch17", NREQ'(1) << 5, NCH'(1) << 17);
        req_chk("R4 req5 and req70", (NREQ'(1) << 5) | (NREQ'(1) << 70),
                (NCH'(1) << 17) | (NCH'(1) << 3));
        req_chk("R4 req6 shares ch17", NREQ'(1) << 6, NCH'(1) << 17);
        req_chk("R4 unmapped req4", NREQ'(1) << 4, '0);
    endtask

    task automatic t_unmap();
        wr(13'h0114, 8'h00);
        req_chk("R5 req5 removed", NREQ'(1) << 5, '0);
        req_chk("R5 req6 kept", NREQ'(1) << 6, NCH'(1) << 17);
        wr(13'h1118, 8'h03);
        req_chk("R5 valid clear req70", NREQ'(1) << 70, '0);
        req_in = '0;
    endtask

    task automatic t_priority();
        @(negedge clk);
        ch_ready = (NCH'(1) << 4) | (NCH'(1) << 16) | (NCH'(1) << 31);
        step_grant("R6 ch16 beats ch4", 16);
        finish_burst("R8 release after 16");
        ch_ready = (NCH'(1) << 4) | (NCH'(1) << 31);
        step_grant("R6 ch4 beats ch31", 4);
        finish_burst("R8 release after 4");
        ch_ready = NCH'(1) << 31;
        step_grant("R6 ch31 alone", 31);
        finish_burst("R8 release after 31");
        ch_ready = '0;
    endtask

    task automatic t_rotate();
        @(negedge clk);
        ch_ready = (NCH'(1) << 8) | (NCH'(1) << 9) | (NCH'(1) << 24);
        step_grant("R7 first ch8", 8);
        finish_burst("R8 release rr1");
        step_grant("R7 then ch9", 9);
        finish_burst("R8 release rr2");
        step_grant("R7 then ch24", 24);
        finish_burst("R8 release rr3");
        step_grant("R7 wrap to ch8", 8);
        finish_burst("R8 release rr4");
        ch_ready = '0;
    endtask

    task automatic t_hold();
        @(negedge clk);
        ch_ready = NCH'(1) << 0;
        step_grant("R8 grant ch0", 0);
        @(negedge clk);
        ch_ready = '0;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            chk("R8 grant held", 64'(grant), 64'd1);
        end
        finish_burst("R8 release after hold");
    endtask

    task automatic t_idle_done();
        @(negedge clk);
        burst_done = 1'b1;
        @(posedge clk); #1;
        chk("R9 done in idle", 64'(grant), 64'd0);
        @(negedge clk);
        burst_done = 1'b0;
        ch_ready = NCH'(1) << 12;
        step_grant("R9 grant ch12", 12);
        finish_burst("R8 release ch12");
        ch_ready = '0;
    endtask

    initial begin
        t_reset();
        t_map();
        t_route();
        t_unmap();
        t_priority();
        t_rotate();
        t_hold();
        t_idle_done();
        repeat (2) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done_flag) begin
            done_flag = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule